// File: doc/BRIEF.md
# NAND Segment Hamming ECC Engine

This engine watches every byte that moves through a NAND controller's data register, in either direction, and builds a 3-byte Hamming parity code for each 256-byte segment. It keeps the codes of up to `NUM_SEGS` segments, so one page can have several codes. Software then reads the codes back through the same data register and does any correction itself.

A 2-bit mode field in the control register sets what the engine does. The reset mode clears all stored codes and counters. The accumulate mode folds each transferred byte into the running code. The off mode freezes everything. The readout mode turns data-register reads into reads of the stored code bytes. A typical page goes reset, then off, then accumulate, then the data transfer. After that comes off, then readout, one read per code byte, and off again.

Top module: `nand_ecc_engine`

## Requirements
- R1: After `rst_ni` is released the mode is off, `code_o` is 0, and every stored code byte reads back as 0x00.
- R2: A pulse on `ctl_we_i` loads `ctl_wdata_i[6:5]` into the mode field, where 00 = off, 01 = accumulate, 10 = readout and 11 = reset. The other bits of `ctl_wdata_i` have no effect.
- R3: In accumulate mode, each cycle with `dat_stb_i` high takes `dat_i` as the next byte of the current segment. When the 256th byte arrives, the segment's code is stored and the next segment begins.
- R4: The code word is defined as follows.
  - lt[k] is the XOR of the bit-parities of the bytes whose in-segment address has bit k set. lc[k] is the same for the bytes whose address has bit k clear.
  - c is the XOR of all bytes in the segment. From it: P4 = ^c[7:4], P4' = ^c[3:0], P2 = c7^c6^c3^c2, P2' = c5^c4^c1^c0, P1 = c7^c5^c3^c1, P1' = c6^c4^c2^c0.
  - Before inversion, byte A = {lt3,lc3,lt2,lc2,lt1,lc1,lt0,lc0}, byte B = {lt7,lc7,lt6,lc6,lt5,lc5,lt4,lc4} and byte C = {P4,P4',P2,P2',P1,P1',0,0}.
  - All three bytes are stored inverted.
- R5: A segment of 256 bytes of 0xFF gives the code bytes 0xFF, 0xFF, 0xFF.
- R6: In readout mode, `code_o` shows the code byte at the read pointer. Each `dat_stb_i` moves the pointer on by one. Per segment the order is B, then A, then C, and segments come in ascending order.
- R7: Any cycle outside readout mode returns the read pointer to segment 0, byte B. After the C byte of the last slot, the pointer wraps to segment 0.
- R8: In off mode, strobes change neither the running code nor the byte count. A later return to accumulate continues the same segment.
- R9: Reset mode clears every stored code to 0x000000 and sets the byte and segment counters to zero.
- R10: Once `NUM_SEGS` codes are stored, further accumulate strobes are ignored and the stored codes are kept.
- R11: `code_o` is 0x00 whenever the mode is not readout.
- R12: A segment with fewer than 256 bytes accumulated stores no code; its slot keeps its cleared value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data; mode field in bits 6:5 |
| dat_stb_i | input | 1 | One data register access (transfer or code read) this cycle |
| dat_i | input | 8 | Byte moving through the data register |
| code_o | output | 8 | Code byte at the read pointer in readout mode, else 0 |

## Verification
The checks assume that mode changes come only from `ctl_we_i`, and that in readout mode every `dat_stb_i` is a read that takes the byte then shown on `code_o`. The stimulus drives strobes only between whole control writes and applies every mode encoding, including writes with unrelated control bits set. Segment fills stop at the 256-byte boundary or are broken up on purpose by off periods. The storage limit is crossed only with whole extra segments, so the saturation and freeze properties see clean sequences.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int SEG_BYTES = 256;
  localparam int ADDR_W    = $clog2(SEG_BYTES);
  localparam int CODE_W    = 24;
  localparam int MODE_LSB  = 5;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ACC = 2'b01,
    MODE_RD  = 2'b10,
    MODE_RST = 2'b11
  } ecc_mode_e;

  // {C, B, A}, inverted so an erased segment codes to all ones
  function automatic logic [CODE_W-1:0] form_code(input logic [7:0] col,
                                                 input logic [ADDR_W-1:0] lt,
                                                 input logic [ADDR_W-1:0] lc);
    logic [7:0] a, b, c;
    for (int k = 0; k < 4; k++) begin
      a[2*k+1] = lt[k];
      a[2*k]   = lc[k];
      b[2*k+1] = lt[k+4];
      b[2*k]   = lc[k+4];
    end
    c[7] = ^col[7:4];
    c[6] = ^col[3:0];
    c[5] = col[7] ^ col[6] ^ col[3] ^ col[2];
    c[4] = col[5] ^ col[4] ^ col[1] ^ col[0];
    c[3] = col[7] ^ col[5] ^ col[3] ^ col[1];
    c[2] = col[6] ^ col[4] ^ col[2] ^ col[0];
    c[1:0] = 2'b00;
    return ~{c, b, a};
  endfunction

endpackage

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [7:0]        data_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);

  logic [ADDR_W-1:0] cnt_q;
  logic [7:0]        col_q, col_n;
  logic [ADDR_W-1:0] lt_q, lt_n, lc_q, lc_n;
  logic              bpar;

  always_comb begin
    bpar  = ^data_i;
    col_n = col_q ^ data_i;
    lt_n  = lt_q ^ ({ADDR_W{bpar}} & cnt_q);
    lc_n  = lc_q ^ ({ADDR_W{bpar}} & ~cnt_q);
  end

  assign done_o = en_i && (cnt_q == {ADDR_W{1'b1}});
  assign code_o = form_code(col_n, lt_n, lc_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      col_q <= '0;
      lt_q  <= '0;
      lc_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      col_q <= '0;
      lt_q  <= '0;
      lc_q  <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (done_o) begin
        col_q <= '0;
        lt_q  <= '0;
        lc_q  <= '0;
      end else begin
        col_q <= col_n;
        lt_q  <= lt_n;
        lc_q  <= lc_n;
      end
    end
  end

endmodule

// File: rtl/nand_ecc_store.sv
module nand_ecc_store
  import nand_ecc_pkg::*;
#(
  parameter int NUM_SEGS = 8,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
  localparam int CNT_W = $clog2(NUM_SEGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic [SEG_W-1:0]  rd_seg_i,
  output logic [CODE_W-1:0] rd_code_o,
  output logic [CNT_W-1:0]  wr_seg_o
);

  logic [CODE_W-1:0] slot_q [NUM_SEGS];
  logic [CNT_W-1:0]  wr_seg_q;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q[g] <= '0;
      else if (clr_i)                             slot_q[g] <= '0;
      else if (wr_i && wr_seg_q == CNT_W'(g))     slot_q[g] <= wr_code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   wr_seg_q <= '0;
    else if (clr_i)                                wr_seg_q <= '0;
    else if (wr_i && wr_seg_q != CNT_W'(NUM_SEGS)) wr_seg_q <= wr_seg_q + 1'b1;
  end

  assign rd_code_o = slot_q[rd_seg_i];
  assign wr_seg_o  = wr_seg_q;

endmodule

// File: rtl/nand_ecc_rdptr.sv
module nand_ecc_rdptr #(
  parameter int NUM_SEGS = 8,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [1:0]       pos_o
);

  logic [SEG_W-1:0] seg_q;
  logic [1:0]       pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= '0;
      pos_q <= '0;
    end else if (clr_i) begin
      seg_q <= '0;
      pos_q <= '0;
    end else if (adv_i) begin
      if (pos_q == 2'd2) begin
        pos_q <= '0;
        seg_q <= (seg_q == SEG_W'(NUM_SEGS - 1)) ? '0 : seg_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign seg_o = seg_q;
  assign pos_o = pos_q;

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int NUM_SEGS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [7:0] ctl_wdata_i,
  input  logic       dat_stb_i,
  input  logic [7:0] dat_i,
  output logic [7:0] code_o
);

  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;
  localparam int CNT_W = $clog2(NUM_SEGS + 1);

  ecc_mode_e         mode_q;
  logic              clr, acc_en, rd_adv, seg_done, full;
  logic [CODE_W-1:0] new_code, rd_code;
  logic [CNT_W-1:0]  wr_seg;
  logic [SEG_W-1:0]  rd_seg;
  logic [1:0]        rd_pos;
  logic [7:0]        sel_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= MODE_OFF;
    else if (ctl_we_i) mode_q <= ecc_mode_e'(ctl_wdata_i[MODE_LSB +: 2]);
  end

  assign clr    = (mode_q == MODE_RST);
  assign full   = (wr_seg == CNT_W'(NUM_SEGS));
  assign acc_en = dat_stb_i && (mode_q == MODE_ACC) && !full;
  assign rd_adv = dat_stb_i && (mode_q == MODE_RD);

  nand_ecc_accum u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (acc_en),
    .data_i (dat_i),
    .done_o (seg_done),
    .code_o (new_code)
  );

  nand_ecc_store #(.NUM_SEGS(NUM_SEGS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_i      (seg_done),
    .wr_code_i (new_code),
    .rd_seg_i  (rd_seg),
    .rd_code_o (rd_code),
    .wr_seg_o  (wr_seg)
  );

  nand_ecc_rdptr #(.NUM_SEGS(NUM_SEGS)) u_rdptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mode_q != MODE_RD),
    .adv_i  (rd_adv),
    .seg_o  (rd_seg),
    .pos_o  (rd_pos)
  );

  // byte order per segment: B, A, C
  always_comb begin
    unique case (rd_pos)
      2'd0:    sel_byte = rd_code[15:8];
      2'd1:    sel_byte = rd_code[7:0];
      default: sel_byte = rd_code[23:16];
    endcase
  end

  assign code_o = (mode_q == MODE_RD) ? sel_byte : 8'h00;

endmodule

// File: rtl/nand_ecc_engine_chk.sv
module nand_ecc_engine_chk #(
  parameter int NUM_SEGS = 8,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
  localparam int CNT_W = $clog2(NUM_SEGS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_we_i,
  input logic [7:0]       ctl_wdata_i,
  input logic [7:0]       code_o,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] wr_seg_i,
  input logic [SEG_W-1:0] rd_seg_i,
  input logic [1:0]       rd_pos_i
);

  a_r2_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (mode_i == $past(ctl_wdata_i[6:5])));

  a_r7_ptr_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10) |=> (rd_seg_i == '0 && rd_pos_i == 2'd0));

  a_r6_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pos_i != 2'd3);

  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> $stable(wr_seg_i));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> (wr_seg_i == '0));

  a_r10_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_seg_i <= CNT_W'(NUM_SEGS));

  a_r11_code_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10) |-> (code_o == 8'h00));

endmodule

bind nand_ecc_engine nand_ecc_engine_chk #(.NUM_SEGS(NUM_SEGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .code_o      (code_o),
  .mode_i      (mode_q),
  .wr_seg_i    (wr_seg),
  .rd_seg_i    (rd_seg),
  .rd_pos_i    (rd_pos)
);

// File: tb/nand_ecc_engine_tb.sv
module nand_ecc_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       stb = 1'b0;
  logic [7:0] dat = 8'h00;
  logic [7:0] code_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_engine #(.NUM_SEGS(NS)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctl_we_i    (we),
    .ctl_wdata_i (wd),
    .dat_stb_i   (stb),
    .dat_i       (dat),
    .code_o      (code_o)
  );

  // reference: byte array per segment, code computed from the definition
  function automatic logic [23:0] ref_code(input logic [7:0] b [256]);
    logic [7:0] col, lt, lc, a, bb, c;
    logic p;
    col = 0; lt = 0; lc = 0;
    for (int i = 0; i < 256; i++) begin
      p = ^b[i];
      col ^= b[i];
      for (int k = 0; k < 8; k++)
        if ((i >> k) & 1) lt[k] ^= p; else lc[k] ^= p;
    end
    for (int k = 0; k < 4; k++) begin
      a[2*k+1] = lt[k];   a[2*k] = lc[k];
      bb[2*k+1] = lt[k+4]; bb[2*k] = lc[k+4];
    end
    c = {^col[7:4], ^col[3:0], col[7]^col[6]^col[3]^col[2], col[5]^col[4]^col[1]^col[0],
         col[7]^col[5]^col[3]^col[1], col[6]^col[4]^col[2]^col[0], 2'b00};
    return ~{c, bb, a};
  endfunction

  int          m_mode, m_cnt, m_nseg, m_ptr;
  logic [7:0]  m_buf [256];
  logic [23:0] m_codes [NS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_nseg = 0; m_ptr = 0;
      for (int i = 0; i < NS; i++) m_codes[i] = 0;
    end else begin
      if (stb && m_mode == 1 && m_nseg < NS) begin
        m_buf[m_cnt] = dat;
        m_cnt++;
        if (m_cnt == 256) begin
          m_codes[m_nseg] = ref_code(m_buf);
          m_nseg++;
          m_cnt = 0;
        end
      end
      if (stb && m_mode == 2) m_ptr = (m_ptr + 1) % (3 * NS);
      if (m_mode != 2) m_ptr = 0;
      if (m_mode == 3) begin
        m_cnt = 0; m_nseg = 0;
        for (int i = 0; i < NS; i++) m_codes[i] = 0;
      end
      if (we) m_mode = int'(wd[6:5]);
    end
  end

  function automatic logic [7:0] model_out();
    logic [23:0] w;
    if (m_mode != 2) return 8'h00;
    w = m_codes[m_ptr / 3];
    case (m_ptr % 3)
      0: return w[15:8];
      1: return w[7:0];
      default: return w[23:16];
    endcase
  endfunction

  // R3 R4 R6 R7 R8 R9 R10 R11: per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (code_o !== model_out()) begin
        fails++;
        $display("FAIL R6 model t=%0t code_o=%h exp=%h", $time, code_o, model_out());
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] w);
    we = 1'b1; wd = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b);
    stb = 1'b1; dat = b;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    v = code_o;
    stb = 1'b1; dat = 8'h00;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0]  v;
    logic [7:0]  arr [256];
    logic [23:0] e;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset code_o", code_o, 8'h00);

    ctl(8'h40); // readout
    for (int i = 0; i < 3; i++) begin rd(v); check("R1 cleared slot", v, 8'h00); end

    ctl(8'h9F); // other bits set, field 00
    check("R2 off despite other bits", code_o, 8'h00);
    ctl(8'h7F); ctl(8'h00); ctl(8'hA5); // reset, off, accumulate (0xA5 -> 01)

    // R12 partial segment
    for (int i = 0; i < 10; i++) xfer(8'h3C);
    check("R11 quiet in accumulate", code_o, 8'h00);
    ctl(8'h00); ctl(8'h40);
    for (int i = 0; i < 3; i++) begin rd(v); check("R12 partial not stored", v, 8'h00); end
    ctl(8'h60); ctl(8'h00); ctl(8'h20);

    // seg0 erased, seg1 single bit, seg2 mixed, seg3 interrupted
    for (int i = 0; i < 256; i++) xfer(8'hFF);
    for (int i = 0; i < 256; i++) xfer(i == 5 ? 8'h01 : 8'h00);
    for (int i = 0; i < 256; i++) xfer(8'(i * 37 + 11));
    for (int i = 0; i < 100; i++) xfer(8'(i) ^ 8'h5A);
    ctl(8'h00);
    for (int i = 0; i < 50; i++) xfer(8'hFF);
    ctl(8'h20);
    for (int i = 100; i < 256; i++) xfer(8'(i) ^ 8'h5A);

    ctl(8'h00); ctl(8'h40);
    for (int i = 0; i < 3; i++) begin rd(v); check("R5 erased segment", v, 8'hFF); end
    rd(v); check("R4 R6 seg1 byte B", v, 8'hAA);
    rd(v); check("R4 R6 seg1 byte A", v, 8'h99);
    rd(v); check("R4 R6 seg1 byte C", v, 8'hAB);
    for (int i = 0; i < 256; i++) arr[i] = 8'(i * 37 + 11);
    e = ref_code(arr);
    rd(v); check("R3 seg2 byte B", v, e[15:8]);
    rd(v); check("R3 seg2 byte A", v, e[7:0]);
    rd(v); check("R3 seg2 byte C", v, e[23:16]);
    for (int i = 0; i < 256; i++) arr[i] = 8'(i) ^ 8'h5A;
    e = ref_code(arr);
    rd(v); check("R8 seg3 byte B", v, e[15:8]);
    rd(v); check("R8 seg3 byte A", v, e[7:0]);
    rd(v); check("R8 seg3 byte C", v, e[23:16]);

    ctl(8'h00); ctl(8'h40);
    rd(v); check("R7 pointer restarts", v, 8'hFF);

    // fill remaining slots, then overflow
    ctl(8'h00); ctl(8'h20);
    for (int s = 4; s < NS; s++)
      for (int i = 0; i < 256; i++) xfer(8'(i * 3 + s));
    for (int i = 0; i < 256; i++) xfer(8'h00);
    ctl(8'h00); ctl(8'h40);
    for (int i = 0; i < 3 * (NS - 1); i++) rd(v);
    for (int i = 0; i < 256; i++) arr[i] = 8'(i * 3 + NS - 1);
    e = ref_code(arr);
    rd(v); check("R10 last slot kept B", v, e[15:8]);
    rd(v); check("R10 last slot kept A", v, e[7:0]);
    rd(v); check("R10 last slot kept C", v, e[23:16]);
    rd(v); check("R7 wrap to seg0", v, 8'hFF);

    ctl(8'h60); ctl(8'h40);
    for (int i = 0; i < 3 * NS; i++) begin rd(v); check("R9 reset clears", v, 8'h00); end
    ctl(8'h00);
    check("R11 quiet in off", code_o, 8'h00);

    finish_run();
  end

endmodule